// File: doc/BRIEF.md
# Staged Power-Down Clock Sequencer

This block decides when each group of a clock generator's outputs may run. Around an active-low power-down request it stops the groups one at a time in a fixed order. Once nothing is running, it switches off the PLL and the crystal oscillator. When the request goes away it restarts them in a different fixed order. Everything is timed by a reference clock. The PLL lock indication and each group's high-to-low output transition come in as synchronous inputs. The block drives one registered run enable per group and one enable each for the PLL and the oscillator.

The seven groups are:

| Bit | Group |
|---|---|
| 0 | PCI |
| 1 | free-running PCI |
| 2 | early buffered 66 MHz output |
| 3 | remaining buffered 66 MHz outputs |
| 4 | CPU-PLL clocks |
| 5 | 48 MHz |
| 6 | REF |

When the block powers up, it goes through the same restart sequence as a power-down exit. A request that returns while a restart is still in progress sends the block straight into the stop sequence from its current state. A request that clears during a stop sequence does not interrupt it.

Top module: `clkgrp_pwrseq`

## Requirements
- R1: The power-down request takes effect only when it is sampled low on two consecutive reference edges. A low seen at one edge alone leaves every output unchanged.
- R2: In the run state, with all transition strobes active, the PCI enable (bit 0) drops on the 4th edge after the first low sample of the request.
- R3: Groups stop in this order: PCI, then free-running PCI, then both buffered 66 MHz groups (bits 2 and 3) together, then CPU-PLL (bit 4), then 48 MHz (bit 5), then REF (bit 6). Each slot takes two edges when its strobe is active.
- R4: Free-running PCI (bit 1) stops in its own slot when the PCI stop request is low at that slot. Otherwise it keeps running and stops in the REF slot, together with REF.
- R5: A group's enable drops only on the edge at which its high-to-low strobe is sampled high. While the strobe stays low, the sequence waits in that slot.
- R6: The PLL and oscillator enables go low one edge after the last group has stopped. Neither is low while any group runs.
- R7: From the off state, a request sampled high on two edges raises the PLL and oscillator enables on the 3rd edge after the first high sample. No group runs until lock is seen.
- R8: On the edge after lock is sampled high, the CPU-PLL group (bit 4) and the early buffered output (bit 2) start together.
- R9: The other buffered outputs (bit 3) start DLY edges after the CPU-PLL group, where DLY = REF_CLK_KHZ*DELAY_US/1000. The default DLY is 1431 edges, which is 100 µs at 14.318 MHz and inside the 30–400 µs window.
- R10: Both PCI groups (bits 0 and 1) start one edge after bit 3. The 48 MHz and REF groups (bits 5 and 6) start one edge after that.
- R11: After reset, every group enable is low and the PLL and oscillator enables are high. The restart sequence then follows R8–R10.
- R12: A request that falls during the restart sequence starts the stop sequence at once. Slots whose groups are already stopped are skipped at one edge each, and groups not yet started never start.
- R13: A request that rises during the stop sequence does not cut it short. The block reaches the off state and re-enables the PLL and oscillator on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; every stage advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Active-low power-down request |
| pci_hold_n | input | 1 | Active-low stop request for the PCI group |
| pll_locked | input | 1 | PLL lock indication |
| grp_fall | input | 7 | Per-group strobe: that group's output has a high-to-low transition now |
| grp_run | output | 7 | Per-group run enable (bit order as in the group table) |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Crystal oscillator enable |

## Verification
Every result has a fixed latency in reference edges, counted from the edge at which the stimulus is first sampled:

| Result | Due |
|---|---|
| Request filter | 2 edges |
| Leaving the run state | 1 more edge |
| First stop (PCI) | 4th edge |
| Each later stop slot | 2 edges |
| Power-on after the off state is left | 3 edges |
| Early release after lock | 1 edge |
| Late release | DLY edges after the early release |
| Each following release | 1 edge |

The bench drives inputs on falling edges and counts rising edges. A monitor on falling edges records the count at which each enable changes. Each scenario compares those counts against the exact sums above rather than polling for an eventual change. Scenarios where something must not happen are checked by confirming that no change was recorded.

// File: rtl/clkgrp_pwrseq_pkg.sv
package clkgrp_pwrseq_pkg;

    localparam int NGRP = 7;

    localparam int G_PCI   = 0;
    localparam int G_PCIF  = 1;
    localparam int G_BUF1  = 2;
    localparam int G_BUF02 = 3;
    localparam int G_CPU   = 4;
    localparam int G_M48   = 5;
    localparam int G_REF   = 6;

    localparam logic [NGRP-1:0] M_PCI   = NGRP'(1) << G_PCI;
    localparam logic [NGRP-1:0] M_PCIF  = NGRP'(1) << G_PCIF;
    localparam logic [NGRP-1:0] M_BUF1  = NGRP'(1) << G_BUF1;
    localparam logic [NGRP-1:0] M_BUF02 = NGRP'(1) << G_BUF02;
    localparam logic [NGRP-1:0] M_CPU   = NGRP'(1) << G_CPU;
    localparam logic [NGRP-1:0] M_M48   = NGRP'(1) << G_M48;
    localparam logic [NGRP-1:0] M_REF   = NGRP'(1) << G_REF;

    localparam int STG_W = 3;
    localparam logic [STG_W-1:0] LAST_STG = 3'd5;

    typedef enum logic [2:0] {
        S_WAKE,
        S_DELAY,
        S_REL_PCI,
        S_REL_SLOW,
        S_RUN,
        S_ENTRY,
        S_OFF
    } seq_state_e;

    typedef struct packed {
        seq_state_e         st;
        logic [STG_W-1:0]   stg;
        logic [NGRP-1:0]    run;
        logic               pll_en;
        logic               osc_en;
    } seq_regs_t;

    // Groups that a given stop slot must have halted before moving on.
    function automatic logic [NGRP-1:0] stage_mask(input logic [STG_W-1:0] stg,
                                                   input logic hold_n);
        case (stg)
            3'd0:    stage_mask = M_PCI;
            3'd1:    stage_mask = hold_n ? '0 : M_PCIF;
            3'd2:    stage_mask = M_BUF1 | M_BUF02;
            3'd3:    stage_mask = M_CPU;
            3'd4:    stage_mask = M_M48;
            default: stage_mask = M_REF | M_PCIF;
        endcase
    endfunction

endpackage

// File: rtl/clkgrp_req_filter.sv
module clkgrp_req_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic filt_n
);

    typedef struct packed {
        logic smp;
        logic filt;
    } flt_regs_t;

    flt_regs_t cur_q, nxt_d;

    // The filtered level follows the input only after two equal samples.
    always_comb begin
        nxt_d     = cur_q;
        nxt_d.smp = req_n;
        if (req_n == cur_q.smp) begin
            nxt_d.filt = req_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{smp: 1'b1, filt: 1'b1};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign filt_n = cur_q.filt;

    // R1: a change of the filtered level needs the previous two samples to agree.
    assert_filter_two_samples_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.filt != $past(cur_q.filt)) |-> ($past(req_n) == $past(cur_q.smp)));

endmodule

// File: rtl/clkgrp_wake_delay.sv
module clkgrp_wake_delay #(
    parameter int DLY_CYCLES = 1431
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_en,
    output logic expired
);

    localparam int CNT_W = $clog2(DLY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_en ? (cnt_q + CNT_W'(1)) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == CNT_W'(DLY_CYCLES - 1));

    // R9: a running count advances one step per enabled edge.
    assert_delay_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_en) && !$past(expired)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/clkgrp_stage_fsm.sv
module clkgrp_stage_fsm
    import clkgrp_pwrseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            filt_n,
    input  logic            hold_n,
    input  logic            pll_locked,
    input  logic            dly_done,
    input  logic [NGRP-1:0] grp_fall,
    output logic            dly_en,
    output logic [NGRP-1:0] run,
    output logic            pll_en,
    output logic            osc_en
);

    localparam logic [NGRP-1:0] EARLY_MASK = M_CPU | M_BUF1;
    localparam logic [NGRP-1:0] PCI_MASK   = M_PCI | M_PCIF;
    localparam logic [NGRP-1:0] SLOW_MASK  = M_M48 | M_REF;

    seq_regs_t       cur_q, nxt_d;
    logic [NGRP-1:0] pend;

    always_comb begin
        nxt_d  = cur_q;
        pend   = cur_q.run & stage_mask(cur_q.stg, hold_n);
        dly_en = 1'b0;
        unique case (cur_q.st)
            S_WAKE: begin
                nxt_d.pll_en = 1'b1;
                nxt_d.osc_en = 1'b1;
                if (!filt_n) begin
                    nxt_d.st  = S_ENTRY;
                    nxt_d.stg = '0;
                end else if (pll_locked) begin
                    nxt_d.run = cur_q.run | EARLY_MASK;
                    nxt_d.st  = S_DELAY;
                end
            end
            S_DELAY: begin
                dly_en = 1'b1;
                if (!filt_n) begin
                    nxt_d.st  = S_ENTRY;
                    nxt_d.stg = '0;
                end else if (dly_done) begin
                    nxt_d.run = cur_q.run | M_BUF02;
                    nxt_d.st  = S_REL_PCI;
                end
            end
            S_REL_PCI: begin
                if (!filt_n) begin
                    nxt_d.st  = S_ENTRY;
                    nxt_d.stg = '0;
                end else begin
                    nxt_d.run = cur_q.run | PCI_MASK;
                    nxt_d.st  = S_REL_SLOW;
                end
            end
            S_REL_SLOW: begin
                if (!filt_n) begin
                    nxt_d.st  = S_ENTRY;
                    nxt_d.stg = '0;
                end else begin
                    nxt_d.run = cur_q.run | SLOW_MASK;
                    nxt_d.st  = S_RUN;
                end
            end
            S_RUN: begin
                if (!filt_n) begin
                    nxt_d.st  = S_ENTRY;
                    nxt_d.stg = '0;
                end
            end
            S_ENTRY: begin
                if (pend == '0) begin
                    if (cur_q.stg == LAST_STG) begin
                        nxt_d.st     = S_OFF;
                        nxt_d.pll_en = 1'b0;
                        nxt_d.osc_en = 1'b0;
                    end else begin
                        nxt_d.stg = cur_q.stg + 3'd1;
                    end
                end else begin
                    nxt_d.run = cur_q.run & ~(pend & grp_fall);
                end
            end
            S_OFF: begin
                if (filt_n) begin
                    nxt_d.st     = S_WAKE;
                    nxt_d.pll_en = 1'b1;
                    nxt_d.osc_en = 1'b1;
                end
            end
            default: begin
                nxt_d.st = S_WAKE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: S_WAKE, stg: '0, run: '0, pll_en: 1'b1, osc_en: 1'b1};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign run    = cur_q.run;
    assign pll_en = cur_q.pll_en;
    assign osc_en = cur_q.osc_en;

    // R5: an enable only drops on an edge where that group's strobe was seen.
    for (genvar g = 0; g < NGRP; g++) begin : g_stop_chk
        assert_stop_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cur_q.run[g]) |-> $past(grp_fall[g]));
    end

    // R3: CPU-PLL clocks stop only after PCI and both buffered groups.
    assert_cpu_after_buffers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_q.run[G_CPU]) |-> (!cur_q.run[G_PCI] && !cur_q.run[G_BUF1] && !cur_q.run[G_BUF02]));

    // R6: oscillator off means nothing runs.
    assert_osc_off_all_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.osc_en |-> (cur_q.run == '0));

    // R7: a running group always has its PLL enabled.
    assert_run_needs_pll_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.run != '0) |-> cur_q.pll_en);

    // R8: CPU-PLL clocks and the early buffered output start together.
    assert_early_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.run[G_CPU]) |-> cur_q.run[G_BUF1]);

    // R10: PCI starts only after the late buffered outputs and the CPU group.
    assert_pci_after_buf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.run[G_PCI]) |-> (cur_q.run[G_BUF02] && cur_q.run[G_CPU]));

endmodule

// File: rtl/clkgrp_pwrseq.sv
module clkgrp_pwrseq
    import clkgrp_pwrseq_pkg::*;
#(
    parameter int REF_CLK_KHZ = 14318,
    parameter int DELAY_US    = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pd_req_n,
    input  logic            pci_hold_n,
    input  logic            pll_locked,
    input  logic [NGRP-1:0] grp_fall,
    output logic [NGRP-1:0] grp_run,
    output logic            pll_en,
    output logic            osc_en
);

    localparam int DLY_CYCLES = (REF_CLK_KHZ * DELAY_US) / 1000;

    logic filt_n;
    logic dly_en;
    logic dly_done;

    clkgrp_req_filter u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_n  (pd_req_n),
        .filt_n (filt_n)
    );

    clkgrp_wake_delay #(
        .DLY_CYCLES (DLY_CYCLES)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (dly_en),
        .expired (dly_done)
    );

    clkgrp_stage_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .filt_n     (filt_n),
        .hold_n     (pci_hold_n),
        .pll_locked (pll_locked),
        .dly_done   (dly_done),
        .grp_fall   (grp_fall),
        .dly_en     (dly_en),
        .run        (grp_run),
        .pll_en     (pll_en),
        .osc_en     (osc_en)
    );

endmodule

// File: tb/clkgrp_pwrseq_tb.sv
module clkgrp_pwrseq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int KHZ  = 14318;
    localparam int DUS  = 100;
    localparam int DLY  = (KHZ * DUS) / 1000;
    localparam int B_PCI = 0, B_PCIF = 1, B_BUF1 = 2, B_BUF02 = 3, B_CPU = 4, B_M48 = 5, B_REF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_req_n = 1'b1;
    logic       pci_hold_n = 1'b0;
    logic       pll_locked = 1'b0;
    logic [6:0] grp_fall = 7'h7F;
    logic [6:0] grp_run;
    logic       pll_en;
    logic       osc_en;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rise_at [7];
    int fall_at [7];
    int osc_rise_at = -1;
    int osc_fall_at = -1;
    logic [6:0] prev_run = '0;
    logic       prev_osc = 1'b1;
    bit         done = 1'b0;

    clkgrp_pwrseq #(.REF_CLK_KHZ(KHZ), .DELAY_US(DUS)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_req_n   (pd_req_n),
        .pci_hold_n (pci_hold_n),
        .pll_locked (pll_locked),
        .grp_fall   (grp_fall),
        .grp_run    (grp_run),
        .pll_en     (pll_en),
        .osc_en     (osc_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        for (int i = 0; i < 7; i++) begin
            if (grp_run[i] && !prev_run[i]) rise_at[i] = cyc;
            if (!grp_run[i] && prev_run[i]) fall_at[i] = cyc;
        end
        if (osc_en && !prev_osc) osc_rise_at = cyc;
        if (!osc_en && prev_osc) osc_fall_at = cyc;
        prev_run = grp_run;
        prev_osc = osc_en;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_rec();
        for (int i = 0; i < 7; i++) begin
            rise_at[i] = -1;
            fall_at[i] = -1;
        end
        osc_rise_at = -1;
        osc_fall_at = -1;
    endtask

    // Release order after lock is raised at count t1 (R8, R9, R10).
    task automatic check_release(input int t1);
        chk("R8", "cpu rise", rise_at[B_CPU], t1 + 1);
        chk("R8", "early buffer rise", rise_at[B_BUF1], t1 + 1);
        chk("R9", "late buffer rise", rise_at[B_BUF02], t1 + 1 + DLY);
        chk("R10", "pci rise", rise_at[B_PCI], t1 + 2 + DLY);
        chk("R10", "free pci rise", rise_at[B_PCIF], t1 + 2 + DLY);
        chk("R10", "48MHz rise", rise_at[B_M48], t1 + 3 + DLY);
        chk("R10", "ref rise", rise_at[B_REF], t1 + 3 + DLY);
        chk("R10", "all running", int'(grp_run), 127);
    endtask

    task automatic bring_up();
        @(negedge clk);
        pd_req_n = 1'b1;
        wait_n(5);
        pll_locked = 1'b1;
        wait_n(DLY + 8);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11", "run after reset", int'(grp_run), 0);
        chk("R11", "pll after reset", int'(pll_en), 1);
        chk("R11", "osc after reset", int'(osc_en), 1);
        chk("R9", "delay inside 30..400us", int'(DLY * 1000 > 30 * KHZ && DLY * 1000 < 400 * KHZ), 1);
    endtask

    task automatic t_powerup();
        int t1;
        wait_n(8);
        chk("R7", "no run before lock", int'(grp_run), 0);
        clear_rec();
        @(negedge clk);
        pll_locked = 1'b1;
        t1 = cyc;
        wait_n(DLY + 6);
        check_release(t1);
    endtask

    task automatic t_glitch();
        @(negedge clk);
        pd_req_n = 1'b0;
        @(negedge clk);
        pd_req_n = 1'b1;
        wait_n(10);
        chk("R1", "run after single low sample", int'(grp_run), 127);
        chk("R1", "osc after single low sample", int'(osc_en), 1);
    endtask

    task automatic t_entry();
        int t0;
        clear_rec();
        @(negedge clk);
        pci_hold_n = 1'b0;
        grp_fall = 7'h7F;
        pd_req_n = 1'b0;
        t0 = cyc;
        wait_n(20);
        chk("R2", "pci stop", fall_at[B_PCI], t0 + 4);
        chk("R4", "free pci stop", fall_at[B_PCIF], t0 + 6);
        chk("R3", "early buffer stop", fall_at[B_BUF1], t0 + 8);
        chk("R3", "late buffer stop", fall_at[B_BUF02], t0 + 8);
        chk("R3", "cpu stop", fall_at[B_CPU], t0 + 10);
        chk("R3", "48MHz stop", fall_at[B_M48], t0 + 12);
        chk("R3", "ref stop", fall_at[B_REF], t0 + 14);
        chk("R6", "osc off", osc_fall_at, t0 + 15);
        chk("R6", "pll off", int'(pll_en), 0);
        pll_locked = 1'b0;
    endtask

    task automatic t_exit();
        int t0;
        int t1;
        clear_rec();
        @(negedge clk);
        pd_req_n = 1'b1;
        t0 = cyc;
        wait_n(12);
        chk("R7", "osc on", osc_rise_at, t0 + 3);
        chk("R7", "pll on", int'(pll_en), 1);
        chk("R7", "no run before lock", int'(grp_run), 0);
        @(negedge clk);
        pll_locked = 1'b1;
        t1 = cyc;
        wait_n(DLY + 6);
        check_release(t1);
    endtask

    task automatic t_edge_wait();
        int t2;
        clear_rec();
        @(negedge clk);
        grp_fall = 7'h7F & ~(7'h01 << B_PCI);
        pd_req_n = 1'b0;
        wait_n(20);
        chk("R5", "pci held without strobe", int'(grp_run[B_PCI]), 1);
        chk("R5", "free pci waits", int'(grp_run[B_PCIF]), 1);
        grp_fall[B_PCI] = 1'b1;
        t2 = cyc;
        @(negedge clk);
        grp_fall[B_PCI] = 1'b0;
        wait_n(2);
        chk("R5", "pci stop on strobe", fall_at[B_PCI], t2 + 1);
        grp_fall = 7'h7F;
        wait_n(20);
        chk("R5", "sequence completes", int'(osc_en), 0);
        pll_locked = 1'b0;
    endtask

    task automatic t_pcif_late();
        int t0;
        bring_up();
        clear_rec();
        @(negedge clk);
        pci_hold_n = 1'b1;
        pd_req_n = 1'b0;
        t0 = cyc;
        wait_n(20);
        chk("R4", "free pci stops with ref", fall_at[B_PCIF], t0 + 13);
        chk("R4", "ref stop", fall_at[B_REF], t0 + 13);
        chk("R4", "osc off", osc_fall_at, t0 + 14);
        pll_locked = 1'b0;
    endtask

    task automatic t_abort();
        int t0;
        clear_rec();
        @(negedge clk);
        pd_req_n = 1'b1;
        wait_n(5);
        pll_locked = 1'b1;
        wait_n(10);
        pd_req_n = 1'b0;
        t0 = cyc;
        wait_n(20);
        chk("R12", "early buffer stop", fall_at[B_BUF1], t0 + 6);
        chk("R12", "cpu stop", fall_at[B_CPU], t0 + 8);
        chk("R12", "late buffer never starts", rise_at[B_BUF02], -1);
        chk("R12", "pci never starts", rise_at[B_PCI], -1);
        chk("R12", "osc off", osc_fall_at, t0 + 11);
        pll_locked = 1'b0;
    endtask

    task automatic t_hold();
        int t0;
        bring_up();
        clear_rec();
        @(negedge clk);
        pci_hold_n = 1'b0;
        pd_req_n = 1'b0;
        pll_locked = 1'b0;
        t0 = cyc;
        wait_n(5);
        pd_req_n = 1'b1;
        wait_n(20);
        chk("R13", "osc off despite request gone", osc_fall_at, t0 + 15);
        chk("R13", "osc back on", osc_rise_at, t0 + 16);
        chk("R13", "no run without lock", int'(grp_run), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        clear_rec();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_powerup();
        t_glitch();
        t_entry();
        t_exit();
        t_edge_wait();
        t_pcif_late();
        t_abort();
        t_hold();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule